// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is a programmable countdown timer that sits beside a processor-local interrupt controller. Software reaches it through word-indexed 32-bit register writes and reads. It chooses a clock prescale ratio, programs a control word that holds the interrupt vector, the mask and the run mode, and starts the timer by writing an initial count. The block divides the input clock, steps the count down once per prescaled tick, and raises a one-cycle interrupt request that carries the programmed vector when the count reaches zero.

In one-shot mode the count rests at zero after expiry. In periodic mode it reloads from the initial count and keeps running. Software can read the remaining count at any time. This allows a calibration run with the mask set: software reads the count after a known interval and computes the elapsed ticks as the initial count minus the value read. A pending flag in the control word records a delivered request until the interrupt logic acknowledges it.

Top module: `lit_countdown_timer`

## Requirements
- R1: The divide register keeps only bits 3, 1 and 0, and bit 2 reads as zero. The value formed from those three bits selects the prescale ratio: 0 gives /2, 1 gives /4, 2 gives /8, 3 gives /16, 8 gives /32, 9 gives /64, 10 gives /128 and 11 gives /1.
- R2: The control word layout is fixed. Bits [7:0] hold the vector, bit 12 holds the pending status, bit 16 holds the mask and bits [18:17] hold the mode. Every other bit reads as zero. Bit 12 is read-only, so writes to it are ignored.
- R3: A nonzero write to the initial count loads the current count and starts the timer. An unmasked expiry is then seen exactly initial count × ratio cycles after the write edge.
- R4: A zero write to the initial count stops the timer and clears the current count. No interrupt follows.
- R5: The register word indices are 0x32 for control, 0x38 for initial count, 0x39 for current count and 0x3E for divide. The current count reads back the live remaining count.
- R6: Each expiry (count stepping 1 to 0) with the mask clear drives `irq_valid` high for one cycle with `irq_vector` equal to bits [7:0] of the control word. With the mask set, no request is made, but the timer still counts.
- R7: The pending status goes to 1 on an unmasked expiry and stays at 1 until `ack` is pulsed.
- R8: In periodic mode (mode 1) the count reloads from the initial count on expiry. In modes 0, 2 and 3 the count stays at zero until the initial count is written again.
- R9: A divide write takes effect at the next prescaler boundary. A write to the initial count restarts the prescaler phase from zero.
- R10: After reset, the control word reads 0x00010000 (masked, mode 0, vector 0). The divide register, the initial count and the current count all read 0, and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word index for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| ack | input | 1 | Clears the pending status |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
The hardest case to reach from the ports is a divide change that lands partway through a run. The new ratio must start only at the next prescaler boundary, and its effect can be seen only through the rate at which the current count moves. The stimulus runs the timer at /1 and switches to /2 mid-count. It then reads the count just after the change and again five cycles later, expecting exactly three decrements. A second directed case restarts a /2 run at an odd phase and checks that the first decrement comes two edges after the write, not one.

// File: rtl/lit_timer_pkg.sv
package lit_timer_pkg;

   localparam logic [7:0] IDX_CTRL = 8'h32;
   localparam logic [7:0] IDX_INIT = 8'h38;
   localparam logic [7:0] IDX_CUR  = 8'h39;
   localparam logic [7:0] IDX_DIV  = 8'h3E;

   localparam int VEC_W    = 8;
   localparam int STAT_BIT = 12;
   localparam int MASK_BIT = 16;
   localparam int MODE_LSB = 17;

   typedef enum logic [1:0] {
      MODE_ONCE   = 2'd0,
      MODE_REPEAT = 2'd1,
      MODE_STAMP  = 2'd2,
      MODE_RSVD   = 2'd3
   } tmr_mode_e;

   // Compressed divide code {b3,b1,b0} maps to log2(ratio) as code+1 mod 8.
   function automatic logic [2:0] div_shift(input logic [2:0] code3);
      return code3 + 3'd1;
   endfunction

endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler #(
   parameter int SHIFT_W     = 3,
   parameter int RESET_SHIFT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift_req,
   output logic               tick
);
   localparam int PRE_W = (1 << SHIFT_W) - 1;

   logic [SHIFT_W-1:0] shift_act;
   logic [PRE_W-1:0]   pcnt;
   logic [PRE_W:0]     lim_full;

   assign lim_full = ((PRE_W+1)'(1) << shift_act) - (PRE_W+1)'(1);
   assign tick     = run && (pcnt == lim_full[PRE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt      <= '0;
         shift_act <= SHIFT_W'(RESET_SHIFT);
      end else if (restart || !run || tick) begin
         pcnt      <= '0;
         shift_act <= shift_req;
      end else begin
         pcnt <= pcnt + PRE_W'(1);
      end
   end
endmodule

// File: rtl/lit_down_counter.sv
module lit_down_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             repeat_en,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             expire
);
   assign expire = running && tick && (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
      end else if (load) begin
         count   <= load_val;
         running <= |load_val;
      end else if (expire) begin
         if (repeat_en) begin
            count <= reload_val;
         end else begin
            count   <= '0;
            running <= 1'b0;
         end
      end else if (running && tick) begin
         count <= count - CNT_W'(1);
      end
   end
endmodule

// File: rtl/lit_irq_stage.sv
module lit_irq_stage #(
   parameter int VEC_W      = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expire,
   input  logic             mask,
   input  logic [VEC_W-1:0] vector,
   input  logic             ack,
   output logic             irq_valid,
   output logic [VEC_W-1:0] irq_vec,
   output logic             pending
);
   logic fire;
   assign fire = expire && !mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pending <= 1'b0;
      else if (fire)   pending <= 1'b1;
      else if (ack)    pending <= 1'b0;
   end

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_vec   <= '0;
         end else begin
            irq_valid <= fire;
            irq_vec   <= vector;
         end
      end
   end else begin : g_comb
      assign irq_valid = fire;
      assign irq_vec   = vector;
   end
endmodule

// File: rtl/lit_countdown_timer.sv
module lit_countdown_timer
   import lit_timer_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int CNT_W          = 32,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   input  logic              ack,
   output logic              irq_valid,
   output logic [7:0]        irq_vector
);
   localparam int SHIFT_W = 3;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too small for the register indices");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end

   logic [VEC_W-1:0] vec_q;
   logic             mask_q;
   tmr_mode_e        mode_q;
   logic [2:0]       div_q;
   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] cur_cnt;
   logic             cnt_running;
   logic             expire;
   logic             tick;
   logic             pend_q;
   logic             sel_ctrl, sel_init, sel_cur, sel_div;
   logic             init_wr;

   assign sel_ctrl = (addr == ADDR_W'(IDX_CTRL));
   assign sel_init = (addr == ADDR_W'(IDX_INIT));
   assign sel_cur  = (addr == ADDR_W'(IDX_CUR));
   assign sel_div  = (addr == ADDR_W'(IDX_DIV));
   assign init_wr  = wr_en && sel_init;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q  <= '0;
         mask_q <= 1'b1;
         mode_q <= MODE_ONCE;
         div_q  <= '0;
         init_q <= '0;
      end else if (wr_en) begin
         if (sel_ctrl) begin
            vec_q  <= wr_data[VEC_W-1:0];
            mask_q <= wr_data[MASK_BIT];
            mode_q <= tmr_mode_e'(wr_data[MODE_LSB +: 2]);
         end
         if (sel_div)  div_q  <= {wr_data[3], wr_data[1:0]};
         if (sel_init) init_q <= wr_data[CNT_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (sel_ctrl) begin
         rd_data[VEC_W-1:0]      = vec_q;
         rd_data[STAT_BIT]       = pend_q;
         rd_data[MASK_BIT]       = mask_q;
         rd_data[MODE_LSB +: 2]  = mode_q;
      end else if (sel_init) begin
         rd_data[CNT_W-1:0] = init_q;
      end else if (sel_cur) begin
         rd_data[CNT_W-1:0] = cur_cnt;
      end else if (sel_div) begin
         rd_data[3]   = div_q[2];
         rd_data[1:0] = div_q[1:0];
      end
   end

   lit_prescaler #(
      .SHIFT_W     (SHIFT_W),
      .RESET_SHIFT (1)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (cnt_running),
      .restart   (init_wr),
      .shift_req (div_shift(div_q)),
      .tick      (tick)
   );

   lit_down_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (init_wr),
      .load_val   (wr_data[CNT_W-1:0]),
      .tick       (tick),
      .repeat_en  (mode_q == MODE_REPEAT),
      .reload_val (init_q),
      .count      (cur_cnt),
      .running    (cnt_running),
      .expire     (expire)
   );

   lit_irq_stage #(
      .VEC_W      (VEC_W),
      .REGISTERED (IRQ_REGISTERED)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .mask      (mask_q),
      .vector    (vec_q),
      .ack       (ack),
      .irq_valid (irq_valid),
      .irq_vec   (irq_vector),
      .pending   (pend_q)
   );
endmodule

// File: rtl/lit_countdown_timer_chk.sv
module lit_countdown_timer_chk
   import lit_timer_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wr_data,
   input logic              ack,
   input logic              mask_q,
   input logic              pend_q,
   input logic [CNT_W-1:0]  cur_cnt,
   input logic              cnt_running,
   input logic [CNT_W-1:0]  init_q
);
   logic ld, ld_zero;
   assign ld      = wr_en && (addr == ADDR_W'(IDX_INIT));
   assign ld_zero = ld && (wr_data[CNT_W-1:0] == '0);

   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      ld && !ld_zero |=> cnt_running && cur_cnt == $past(wr_data[CNT_W-1:0])); // R3
   AST_ZERO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      ld_zero |=> !cnt_running && cur_cnt == '0); // R4
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_running && !ld && cur_cnt > CNT_W'(1) |=>
         cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - CNT_W'(1)); // R5
   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_running |-> cur_cnt <= init_q && cur_cnt != '0); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_running && !ld |=> $stable(cur_cnt) && !cnt_running); // R8
   AST_MASK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(!mask_q)); // R6
   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !ack |=> pend_q); // R7
endmodule

bind lit_countdown_timer lit_countdown_timer_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .addr        (addr),
   .wr_data     (wr_data),
   .ack         (ack),
   .mask_q      (mask_q),
   .pend_q      (pend_q),
   .cur_cnt     (cur_cnt),
   .cnt_running (cnt_running),
   .init_q      (init_q)
);

// File: tb/lit_countdown_timer_tb.sv
module lit_countdown_timer_tb_top;
   import lit_timer_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [7:0]  addr;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic        ack;
   logic        irq_valid;
   logic [7:0]  irq_vector;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   lit_countdown_timer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .ack        (ack),
      .irq_valid  (irq_valid),
      .irq_vector (irq_vector)
   );

   typedef struct packed {
      logic [3:0]  code;
      logic [7:0]  ratio;
      logic [15:0] init;
      logic        mask;
   } vec_t;

   localparam vec_t TBL [10] = '{
      '{4'd0,  8'd2,   16'd5, 1'b0},
      '{4'd1,  8'd4,   16'd3, 1'b0},
      '{4'd2,  8'd8,   16'd2, 1'b0},
      '{4'd3,  8'd16,  16'd2, 1'b0},
      '{4'd8,  8'd32,  16'd1, 1'b0},
      '{4'd9,  8'd64,  16'd1, 1'b0},
      '{4'd10, 8'd128, 16'd1, 1'b0},
      '{4'd11, 8'd1,   16'd7, 1'b0},
      '{4'd11, 8'd1,   16'd4, 1'b1},
      '{4'd0,  8'd2,   16'd1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wait_irq(input int limit, output int k, output logic [7:0] v);
      k = 0; v = '0;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk);
         if (irq_valid) begin
            k = i; v = irq_vector;
            break;
         end
      end
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] r, v0;
      logic [7:0]  v;
      int          k;
      rst_n = 1'b0; wr_en = 1'b0; ack = 1'b0; addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(IDX_CTRL, r); check("R10 ctrl", r, 32'h0001_0000);
      rd(IDX_DIV, r);  check("R10 div", r, 32'h0);
      rd(IDX_INIT, r); check("R10 init", r, 32'h0);
      rd(IDX_CUR, r);  check("R10 cur", r, 32'h0);
      check("R10 irq", 32'(irq_valid), 32'h0);

      // R2 reserved and read-only bits
      wr(IDX_CTRL, 32'hFFFF_FFFF);
      rd(IDX_CTRL, r); check("R2 ctrl mask", r, 32'h0007_00FF);
      // R1 divide keeps bits 3,1,0
      wr(IDX_DIV, 32'hFFFF_FFFF);
      rd(IDX_DIV, r); check("R1 div bits", r, 32'h0000_000B);

      // Table: ratio per code, vector, mask, pending
      for (int i = 0; i < 10; i++) begin
         wr(IDX_DIV, 32'(TBL[i].code));
         rd(IDX_DIV, r); check("R1 div readback", r, 32'(TBL[i].code));
         wr(IDX_CTRL, (32'(TBL[i].mask) << 16) | 32'(8'h40 + i));
         wr(IDX_INIT, 32'(TBL[i].init));
         wait_irq(int'(TBL[i].init) * int'(TBL[i].ratio) + 6, k, v);
         if (TBL[i].mask) begin
            check("R6 masked no irq", 32'(k), 32'h0);
            rd(IDX_CUR, r); check("R6 masked still counts", r, 32'h0);
            rd(IDX_CTRL, r); check("R7 masked no pending", 32'(r[12]), 32'h0);
         end else begin
            check("R1 R3 expiry cycle", 32'(k), 32'(int'(TBL[i].init) * int'(TBL[i].ratio)));
            check("R6 vector", 32'(v), 32'(8'h40 + i));
            rd(IDX_CTRL, r); check("R7 pending set", 32'(r[12]), 32'h1);
            @(negedge clk);
            check("R6 single cycle", 32'(irq_valid), 32'h0);
            rd(IDX_CTRL, r); check("R7 pending held", 32'(r[12]), 32'h1);
            pulse_ack();
            rd(IDX_CTRL, r); check("R7 pending cleared", 32'(r[12]), 32'h0);
         end
      end

      // R8 mode 2 behaves as one-shot
      wr(IDX_DIV, 32'd11);
      wr(IDX_CTRL, 32'h0004_0021);
      rd(IDX_CTRL, r); check("R2 mode field", r, 32'h0004_0021);
      wr(IDX_INIT, 32'd3);
      wait_irq(10, k, v);
      check("R8 one-shot expiry", 32'(k), 32'd3);
      check("R8 one-shot vector", 32'(v), 32'h21);
      repeat (10) @(negedge clk);
      rd(IDX_CUR, r); check("R8 one-shot stays zero", r, 32'h0);
      wait_irq(10, k, v);
      check("R8 no second irq", 32'(k), 32'h0);
      pulse_ack();

      // R8 periodic reload
      wr(IDX_CTRL, 32'h0002_0033);
      wr(IDX_INIT, 32'd4);
      wait_irq(10, k, v);
      check("R8 periodic first", 32'(k), 32'd4);
      wait_irq(10, k, v);
      check("R8 periodic second", 32'(k), 32'd4);
      rd(IDX_CUR, r); check("R8 periodic reloaded", r, 32'd4);
      pulse_ack();

      // R4 zero write stops
      wr(IDX_INIT, 32'd0);
      rd(IDX_CUR, r); check("R4 count cleared", r, 32'h0);
      wait_irq(20, k, v);
      check("R4 no irq after stop", 32'(k), 32'h0);

      // R5 calibration while masked, /2
      wr(IDX_DIV, 32'd0);
      wr(IDX_CTRL, 32'h0001_0000);
      wr(IDX_INIT, 32'd100);
      repeat (20) @(negedge clk);
      rd(IDX_CUR, r); check("R5 live count", r, 32'd90);
      rd(IDX_INIT, r); check("R5 init readback", r, 32'd100);

      // R9 divide change lands on next boundary
      wr(IDX_DIV, 32'd11);
      wr(IDX_INIT, 32'd1000);
      repeat (3) @(negedge clk);
      wr(IDX_DIV, 32'd0);
      rd(IDX_CUR, v0);
      repeat (5) @(negedge clk);
      rd(IDX_CUR, r); check("R9 divide boundary", r, v0 - 32'd3);

      // R9 initial count write restarts prescaler phase
      @(negedge clk);
      wr(IDX_INIT, 32'd50);
      @(negedge clk);
      rd(IDX_CUR, r); check("R9 restart no early step", r, 32'd50);
      @(negedge clk);
      rd(IDX_CUR, r); check("R9 restart first step", r, 32'd49);
      wr(IDX_INIT, 32'd0);

      finish_run();
   end
endmodule